// File: doc/BRIEF.md
# ADC conversion sequencing controller

This block schedules conversions for a multi-channel successive-approximation analog-to-digital converter. Software programs one control word holding a start bit, a conversion-speed select, an operating mode, a channel field and an interrupt enable. Once started, the block raises a one-cycle request toward the analog front end for each conversion. It then counts a fixed number of clock states and latches the front end's result word into a data register that belongs to the converted channel.

Three operating modes exist. Single mode converts one channel and then drops the start bit. Single-cycle scan walks channels 0 up to the channel field once and then drops the start bit. Continuous scan repeats that walk until software clears the start bit. Each finished round sets a sticky end flag. The flag can drive a level interrupt, and software clears it with a separate write.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the start bit, the speed select, the interrupt enable, the end flag, the interrupt and the request output are 0, the mode is single (00), the channel field is 0, and every data register reads 0.
- R2: A write with `wr_en`=1 and `wr_sel`=0 loads the control word. Bit 0 is start, bit 1 is the fast select, bits 3:2 are the mode (00 single, 01 continuous scan, 10 single-cycle scan, 11 acts as single), bits 7:4 are the channel field and bit 8 is the interrupt enable.
- R3: A conversion lasts N clock cycles, with N = 266 when the fast select is 0 and N = 134 when it is 1. The first conversion begins on the edge after the start bit is written, with `conv_req_o` high for that first cycle only and `conv_ch_o` naming the channel. A round of K conversions started at write edge E completes on edge E+K*N+1.
- R4: In single mode (and mode 11) only the channel named by the channel field is converted, and the start bit clears itself on the completing edge.
- R5: In single-cycle scan mode channels 0 up to the channel field are converted once each in ascending order, after which the start bit clears itself.
- R6: In continuous scan mode the start bit stays 1 at the end of a round, and a new round begins at channel 0 on that same edge.
- R7: Each completed conversion stores `adc_result_i` into the data register of the converted channel. `rd_data` shows the register chosen by `rd_ch` in the same cycle, and other registers are left unchanged.
- R8: The end flag is set at the end of every round and stays set until a write with `wr_sel`=1 and `wr_data` bit 0 = 1. When a set and a clear fall on the same edge, the set wins. `irq_o` is high exactly when the flag and the interrupt enable are both 1.
- R9: While the start bit is 1, a control write changes only the start bit. The mode, channel, speed and interrupt-enable fields keep their values.
- R10: Clearing the start bit during a conversion abandons that conversion. No data register is written and the flag is not set, the sequencer is idle from the next edge, and a later start yields a conversion of the full N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: control word, 1: flag clear |
| wr_data | input | 9 | Write data |
| rd_ch | input | CH_W | Data register read select |
| rd_data | output | DATA_W | Selected data register |
| start_o | output | 1 | Start bit |
| fast_o | output | 1 | Speed select |
| mode_o | output | 2 | Operating mode |
| ch_o | output | CH_W | Channel field |
| ie_o | output | 1 | Interrupt enable |
| end_flag_o | output | 1 | Sticky end-of-round flag |
| irq_o | output | 1 | Interrupt request |
| conv_req_o | output | 1 | Conversion request to front end |
| conv_ch_o | output | CH_W | Channel being converted |
| adc_result_i | input | DATA_W | Result word from front end |

## Verification
The end-of-round flag set and a software flag clear can land on the same clock edge. The bench computes the completing edge from N and the channel count, places the clear write on exactly that edge, and expects the flag to read 1 afterwards. A second overlap, a control write arriving while the sequencer runs, is provoked during a continuous scan. It is judged by reading back the configuration fields and confirming that the scan keeps its original timing and channel order.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'b00,
      MODE_CONT   = 2'b01,
      MODE_ONCE   = 2'b10,
      MODE_RSVD   = 2'b11
   } scan_mode_e;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_CONV = 1'b1
   } seq_state_e;

   localparam int unsigned CTL_W         = 9;
   localparam int unsigned CTL_START_BIT = 0;
   localparam int unsigned CTL_FAST_BIT  = 1;
   localparam int unsigned CTL_MODE_LSB  = 2;
   localparam int unsigned CTL_CH_LSB    = 4;
   localparam int unsigned CTL_IE_BIT    = 8;
   localparam int unsigned CTL_CH_MAX_W  = 4;

endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
   import adc_seq_pkg::*;
#(
   parameter int unsigned CH_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CTL_W-1:0] wr_data,
   input  logic             auto_clr_i,
   input  logic             round_done_i,
   output logic             start_o,
   output logic             fast_o,
   output scan_mode_e       mode_o,
   output logic [CH_W-1:0]  ch_o,
   output logic             ie_o,
   output logic             flag_o,
   output logic             irq_o
);

   initial begin
      assert (CH_W >= 1 && CH_W <= CTL_CH_MAX_W)
         else $error("adc_ctrl_regs: CH_W must lie in 1..%0d", CTL_CH_MAX_W);
   end

   logic       ctl_wr;
   logic       clr_wr;
   logic       start_q;
   logic       fast_q;
   scan_mode_e mode_q;
   logic [CH_W-1:0] ch_q;
   logic       ie_q;
   logic       flag_q;

   assign ctl_wr = wr_en && !wr_sel;
   assign clr_wr = wr_en && wr_sel && wr_data[0];

   // start bit: software write has priority over hardware self-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
      end else if (ctl_wr) begin
         start_q <= wr_data[CTL_START_BIT];
      end else if (auto_clr_i) begin
         start_q <= 1'b0;
      end
   end

   // configuration fields accept writes only while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_q <= 1'b0;
         mode_q <= MODE_SINGLE;
         ch_q   <= '0;
         ie_q   <= 1'b0;
      end else if (ctl_wr && !start_q) begin
         fast_q <= wr_data[CTL_FAST_BIT];
         mode_q <= scan_mode_e'(wr_data[CTL_MODE_LSB +: 2]);
         ch_q   <= wr_data[CTL_CH_LSB +: CH_W];
         ie_q   <= wr_data[CTL_IE_BIT];
      end
   end

   // sticky end flag, set wins over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (round_done_i) begin
         flag_q <= 1'b1;
      end else if (clr_wr) begin
         flag_q <= 1'b0;
      end
   end

   assign start_o = start_q;
   assign fast_o  = fast_q;
   assign mode_o  = mode_q;
   assign ch_o    = ch_q;
   assign ie_o    = ie_q;
   assign flag_o  = flag_q;
   assign irq_o   = flag_q && ie_q;

   // R8
   flag_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(clr_wr));

   // R9
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && $past(start_q)) |->
         ($stable(mode_q) && $stable(ch_q) && $stable(fast_q) && $stable(ie_q)));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned CH_W        = 4,
   parameter int unsigned SLOW_STATES = 266,
   parameter int unsigned FAST_STATES = 134
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            fast_i,
   input  scan_mode_e      mode_i,
   input  logic [CH_W-1:0] ch_field_i,
   output logic            conv_req_o,
   output logic [CH_W-1:0] conv_ch_o,
   output logic            cap_en_o,
   output logic            round_done_o,
   output logic            auto_clr_o
);

   localparam int unsigned CNT_W = $clog2(SLOW_STATES);

   initial begin
      assert (FAST_STATES >= 2)
         else $error("adc_seq_fsm: FAST_STATES must be at least 2");
      assert (SLOW_STATES >= FAST_STATES)
         else $error("adc_seq_fsm: SLOW_STATES must not be below FAST_STATES");
   end

   seq_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CH_W-1:0]  cur_ch_q;

   logic [CNT_W-1:0] len_m1;
   logic             scan_mode;
   logic             last_hit;
   logic             cnt_end;
   logic             cap_en;
   logic             round_done;

   assign len_m1     = fast_i ? CNT_W'(FAST_STATES - 1) : CNT_W'(SLOW_STATES - 1);
   assign scan_mode  = (mode_i == MODE_CONT) || (mode_i == MODE_ONCE);
   assign last_hit   = (cur_ch_q == ch_field_i);
   assign cnt_end    = (state_q == SEQ_CONV) && (cnt_q == len_m1);
   assign cap_en     = cnt_end && start_i;
   assign round_done = cap_en && last_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         cnt_q    <= '0;
         cur_ch_q <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               cnt_q <= '0;
               if (start_i) begin
                  state_q  <= SEQ_CONV;
                  cur_ch_q <= scan_mode ? '0 : ch_field_i;
               end
            end
            SEQ_CONV: begin
               if (!start_i) begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= '0;
               end else if (cnt_end) begin
                  cnt_q <= '0;
                  if (!last_hit) begin
                     cur_ch_q <= cur_ch_q + CH_W'(1);
                  end else if (mode_i == MODE_CONT) begin
                     cur_ch_q <= '0;
                  end else begin
                     state_q <= SEQ_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign conv_req_o   = (state_q == SEQ_CONV) && (cnt_q == '0);
   assign conv_ch_o    = cur_ch_q;
   assign cap_en_o     = cap_en;
   assign round_done_o = round_done;
   assign auto_clr_o   = round_done && (mode_i != MODE_CONT);

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_CONV) |-> (cnt_q <= len_m1));

   // R3
   req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o |=> !conv_req_o);

   // R5
   ch_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_CONV) |-> (cur_ch_q <= ch_field_i));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int unsigned CH_W   = 4,
   parameter int unsigned DATA_W = 10,
   parameter bit          RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CH_W-1:0]   rd_ch,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned NUM_CH = 1 << CH_W;

   initial begin
      assert (DATA_W >= 1)
         else $error("adc_result_bank: DATA_W must be positive");
   end

   logic [NUM_CH*DATA_W-1:0] flat;
   logic [DATA_W-1:0]        rd_sel;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_ch == CH_W'(i))) begin
            q <= wr_data;
         end
      end
      assign flat[i*DATA_W +: DATA_W] = q;
   end

   assign rd_sel = flat[rd_ch*DATA_W +: DATA_W];

   if (RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q <= '0;
         end else begin
            rd_q <= rd_sel;
         end
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = rd_sel;
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned CH_W        = 4,
   parameter int unsigned DATA_W      = 10,
   parameter int unsigned SLOW_STATES = 266,
   parameter int unsigned FAST_STATES = 134,
   parameter bit          RD_REG      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [8:0]        wr_data,
   input  logic [CH_W-1:0]   rd_ch,
   output logic [DATA_W-1:0] rd_data,
   output logic              start_o,
   output logic              fast_o,
   output logic [1:0]        mode_o,
   output logic [CH_W-1:0]   ch_o,
   output logic              ie_o,
   output logic              end_flag_o,
   output logic              irq_o,
   output logic              conv_req_o,
   output logic [CH_W-1:0]   conv_ch_o,
   input  logic [DATA_W-1:0] adc_result_i
);

   scan_mode_e mode_w;
   logic       cap_en;
   logic       round_done;
   logic       auto_clr;
   logic       ctl_wr;

   assign ctl_wr = wr_en && !wr_sel;
   assign mode_o = mode_w;

   adc_ctrl_regs #(
      .CH_W (CH_W)
   ) regs_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .auto_clr_i   (auto_clr),
      .round_done_i (round_done),
      .start_o      (start_o),
      .fast_o       (fast_o),
      .mode_o       (mode_w),
      .ch_o         (ch_o),
      .ie_o         (ie_o),
      .flag_o       (end_flag_o),
      .irq_o        (irq_o)
   );

   adc_seq_fsm #(
      .CH_W        (CH_W),
      .SLOW_STATES (SLOW_STATES),
      .FAST_STATES (FAST_STATES)
   ) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_o),
      .fast_i       (fast_o),
      .mode_i       (mode_w),
      .ch_field_i   (ch_o),
      .conv_req_o   (conv_req_o),
      .conv_ch_o    (conv_ch_o),
      .cap_en_o     (cap_en),
      .round_done_o (round_done),
      .auto_clr_o   (auto_clr)
   );

   adc_result_bank #(
      .CH_W   (CH_W),
      .DATA_W (DATA_W),
      .RD_REG (RD_REG)
   ) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cap_en),
      .wr_ch   (conv_ch_o),
      .wr_data (adc_result_i),
      .rd_ch   (rd_ch),
      .rd_data (rd_data)
   );

   // R4
   single_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (round_done && (mode_w != MODE_CONT) && !ctl_wr) |=> !start_o);

   // R6
   cont_keeps_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (round_done && (mode_w == MODE_CONT) && !ctl_wr) |=> start_o);

   // R8
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      round_done |=> end_flag_o);

   // R10
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_o |=> !conv_req_o);

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

   localparam int SLOW_N = 266;
   localparam int FAST_N = 134;

   // {mode[1:0], fast, ie, ch[3:0], base[9:0]}
   localparam logic [17:0] VEC [6] = '{
      {2'b00, 1'b0, 1'b1, 4'd5,  10'h100},
      {2'b00, 1'b1, 1'b0, 4'd0,  10'h003},
      {2'b10, 1'b1, 1'b1, 4'd3,  10'h200},
      {2'b10, 1'b0, 1'b0, 4'd0,  10'h055},
      {2'b00, 1'b1, 1'b1, 4'd15, 10'h2A0},
      {2'b11, 1'b1, 1'b0, 4'd2,  10'h120}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [8:0] wr_data = '0;
   logic [3:0] rd_ch = '0;
   logic [9:0] rd_data;
   logic       start_o, fast_o, ie_o, end_flag_o, irq_o, conv_req_o;
   logic [1:0] mode_o;
   logic [3:0] ch_o, conv_ch_o;
   logic [9:0] fe_base = '0;
   logic [9:0] adc_result;

   int n_chk = 0;
   int n_fail = 0;
   logic [9:0] exp_data [16];

   always #2.5ns clk = ~clk;

   assign adc_result = fe_base + {6'b0, conv_ch_o};

   adc_seq_ctrl dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .rd_ch        (rd_ch),
      .rd_data      (rd_data),
      .start_o      (start_o),
      .fast_o       (fast_o),
      .mode_o       (mode_o),
      .ch_o         (ch_o),
      .ie_o         (ie_o),
      .end_flag_o   (end_flag_o),
      .irq_o        (irq_o),
      .conv_req_o   (conv_req_o),
      .conv_ch_o    (conv_ch_o),
      .adc_result_i (adc_result)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] mk_ctl(input logic ie, input logic [3:0] ch,
                                         input logic [1:0] mode, input logic fast,
                                         input logic start);
      return {ie, ch, mode, fast, start};
   endfunction

   // called at a negedge; returns at the negedge after the write edge
   task automatic ctl_write(input logic [8:0] d);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic flag_clear();
      wr_en = 1'b1; wr_sel = 1'b1; wr_data = 9'h001;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
   endtask

   task automatic rd_check(input string req, input int c, input logic [9:0] exp);
      rd_ch = 4'(c);
      #0.5ns;
      check(req, {22'b0, rd_data}, {22'b0, exp});
   endtask

   task automatic check_all_data(input string req);
      for (int c = 0; c < 16; c++) rd_check(req, c, exp_data[c]);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < 16; c++) exp_data[c] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 start", start_o, 0);
      check("R1 fast", fast_o, 0);
      check("R1 mode", mode_o, 0);
      check("R1 ch", ch_o, 0);
      check("R1 ie", ie_o, 0);
      check("R1 flag", end_flag_o, 0);
      check("R1 irq", irq_o, 0);
      check("R1 req", conv_req_o, 0);
      check_all_data("R1 data");

      // vector table: R2 R3 R4 R5 R7 R8
      for (int v = 0; v < 6; v++) begin
         logic [1:0] md;
         logic       fs, ie;
         logic [3:0] ch;
         logic [9:0] base;
         int k, n;
         {md, fs, ie, ch, base} = VEC[v];
         fe_base = base;
         k = (md == 2'b01 || md == 2'b10) ? int'(ch) + 1 : 1;
         n = fs ? FAST_N : SLOW_N;
         ctl_write(mk_ctl(ie, ch, md, fs, 1'b1));
         check("R2 mode field", mode_o, md);
         check("R2 ch field", ch_o, ch);
         check("R2 fast field", fast_o, fs);
         check("R2 ie field", ie_o, ie);
         repeat (k * n) @(negedge clk);
         check("R3 still running at K*N", start_o, 1);
         check("R3 flag not yet set", end_flag_o, 0);
         @(negedge clk);
         check((md == 2'b10) ? "R5 start self-clear" : "R4 start self-clear", start_o, 0);
         check("R8 flag set", end_flag_o, 1);
         check("R8 irq follows enable", irq_o, ie);
         if (md == 2'b10) begin
            for (int c = 0; c <= int'(ch); c++) exp_data[c] = base + 10'(c);
         end else begin
            exp_data[ch] = base + 10'(ch);
         end
         check_all_data((md == 2'b10) ? "R5 R7 scan data" : "R4 R7 single data");
         flag_clear();
         check("R8 flag cleared", end_flag_o, 0);
         check("R8 irq cleared", irq_o, 0);
      end

      // continuous scan with ignored write: R3 R6 R9
      fe_base = 10'h300;
      ctl_write(mk_ctl(1'b0, 4'd1, 2'b01, 1'b1, 1'b1));
      @(negedge clk);
      check("R3 request first cycle", conv_req_o, 1);
      check("R3 request channel", conv_ch_o, 0);
      @(negedge clk);
      check("R3 request one cycle", conv_req_o, 0);
      ctl_write(mk_ctl(1'b1, 4'd9, 2'b00, 1'b0, 1'b1));
      check("R9 mode kept", mode_o, 2'b01);
      check("R9 ch kept", ch_o, 1);
      check("R9 fast kept", fast_o, 1);
      check("R9 ie kept", ie_o, 0);
      repeat (2 * FAST_N + 1 - 3) @(negedge clk);
      check("R6 start kept", start_o, 1);
      check("R6 flag set", end_flag_o, 1);
      check("R6 new round request", conv_req_o, 1);
      check("R6 new round channel", conv_ch_o, 0);
      rd_check("R6 round1 ch0", 0, 10'h300);
      rd_check("R6 round1 ch1", 1, 10'h301);
      fe_base = 10'h310;
      repeat (2 * FAST_N) @(negedge clk);
      rd_check("R6 round2 ch0", 0, 10'h310);
      rd_check("R6 round2 ch1", 1, 10'h311);
      check("R6 still running", start_o, 1);
      exp_data[0] = 10'h310;
      exp_data[1] = 10'h311;
      @(negedge clk);
      ctl_write(9'h000);
      check("R10 stop clears start", start_o, 0);
      repeat (3) @(negedge clk);
      check("R10 idle no request", conv_req_o, 0);
      flag_clear();

      // abort mid-conversion: R10
      fe_base = 10'h1F0;
      ctl_write(mk_ctl(1'b0, 4'd7, 2'b00, 1'b0, 1'b1));
      repeat (50) @(negedge clk);
      ctl_write(mk_ctl(1'b0, 4'd7, 2'b00, 1'b0, 1'b0));
      @(negedge clk);
      check("R10 no request after abort", conv_req_o, 0);
      repeat (300) @(negedge clk);
      check("R10 start low", start_o, 0);
      check("R10 flag not set", end_flag_o, 0);
      check_all_data("R10 no data write");
      ctl_write(mk_ctl(1'b0, 4'd7, 2'b00, 1'b0, 1'b1));
      repeat (SLOW_N) @(negedge clk);
      check("R10 restart full length", start_o, 1);
      @(negedge clk);
      check("R10 restart completes", start_o, 0);
      exp_data[7] = 10'h1F7;
      rd_check("R10 restart data", 7, 10'h1F7);
      @(negedge clk);
      flag_clear();

      // set and clear of the flag on the same edge: R8
      fe_base = 10'h0A0;
      ctl_write(mk_ctl(1'b1, 4'd4, 2'b00, 1'b1, 1'b1));
      repeat (FAST_N) @(negedge clk);
      check("R8 flag low before end", end_flag_o, 0);
      flag_clear();
      check("R8 set wins over clear", end_flag_o, 1);
      check("R8 irq with enable", irq_o, 1);
      check("R4 single done", start_o, 0);
      flag_clear();
      check("R8 later clear works", end_flag_o, 0);
      exp_data[4] = 10'h0A4;
      check_all_data("R7 final data");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule